// File: doc/BRIEF.md
# Calendar Timekeeping and Update-Cycle Engine

This block holds a calendar clock: seconds, minutes, hours, day of week, day of month, month and a two-digit year. A tick input, pulsed once per cycle of a reference divider, is counted down to a one-second boundary. At that boundary the engine steps the whole calendar in one edge, carrying from each field into the next. The count runs natively in whichever encoding the data-mode control bit selects, packed BCD or plain binary. Hours run in either 24-hour form or 12-hour form with a PM flag.

Each step is framed by an update window. A status flag rises a fixed number of ticks before the registers change and stays high for a fixed number of ticks afterwards. While the flag is high, host writes to the time fields are dropped, so software that polls the flag never loads a field during the step. When the window closes, a one-cycle done pulse is issued. Setting the hold bit in the control register freezes all stepping so that software can load a consistent time. A small register port reads and writes the fields and the mode bits.

Top module: `rtc_timekeeper`

## Requirements
- R1: After reset, seconds, minutes and hours read 0x00, day of week, day of month and month read 0x01, year reads 0x00, the control register (index 11) reads 0x02 and the status register (index 10) reads 0x00.
- R2: With control bit 2 clear, every field counts in packed BCD. Seconds and minutes wrap 59 to 0, 24-hour hours wrap 23 to 0, and each wrap carries into the next field. For example, 0x09 seconds steps to 0x10.
- R3: With control bit 2 set, every field counts in plain binary with the same ranges, so 59 seconds reads 0x3B before a step and 0x00 after it.
- R4: With control bit 1 clear, hours run from 1 to 12 with bit 7 of the hours field as the PM flag. A step from 11 goes to 12 and toggles PM. A step from 12 goes to 1 with PM unchanged. A step from 11 PM to 12 AM carries into the date.
- R5: Day of week runs 1 to 7. Day of month wraps to 1 after the length of the current month (30 for months 4, 6, 9 and 11, 31 otherwise apart from February). Month wraps 12 to 1 and year wraps 99 to 0.
- R6: February has 29 days when the year value is divisible by 4 and 28 days otherwise.
- R7: While control bit 7 (hold) is set, no field steps, the status flag stays low, no done pulse appears, and host writes to the time fields take effect.
- R8: The update flag (output `uip`, bit 7 of index 10) rises WARN_TICKS ticks before the fields change.
- R9: The flag stays high for UPDATE_TICKS ticks after the change, WARN_TICKS+UPDATE_TICKS in total. `upd_done` is high for exactly the one cycle in which the flag reads low again.
- R10: A write to a time field while the flag is high and hold is clear is ignored.
- R11: The calendar advances only on cycles with `tick` high. With `tick` low, the flag, the done pulse and the fields do not move.
- R12: Register indices are 0 seconds, 2 minutes, 4 hours, 6 day of week, 7 day of month, 8 month, 9 year, 10 status and 11 control. The control register keeps bits 7, 2 and 1 only. All unused indices read 0x00. A read returns the addressed value one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One pulse per reference-divider period |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register index for read and write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data for the index of the previous cycle |
| uip | output | 1 | Update window flag |
| upd_done | output | 1 | One-cycle pulse when the update window closes |

## Verification
The bench goes after the full-carry step from 23:59:59 on the last day of the year, where a broken carry would leave a field at 60, 24, 32 or 13 or fail to reach the year. It also covers a 30-day month, February in a leap year and in a common year, and the 12-hour transitions around noon and midnight, where a wrong PM toggle or a missing date carry gives a clock off by twelve hours or a day. It measures the update window cycle by cycle, which shows a flag that rises late, a step placed wrongly inside the window, and a done pulse that does not line up with the falling flag. A write during the window must be dropped, and both the hold bit and a stopped tick must freeze the calendar. A design that let the write through or kept counting would show a changed seconds value.

// File: rtl/rtc_tk_pkg.sv
package rtc_tk_pkg;

  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic [DATA_W-1:0] sec;
    logic [DATA_W-1:0] min;
    logic [DATA_W-1:0] hour;
    logic [DATA_W-1:0] dow;
    logic [DATA_W-1:0] dom;
    logic [DATA_W-1:0] mon;
    logic [DATA_W-1:0] year;
  } rtc_time_t;

  localparam logic [ADDR_W-1:0] IX_SEC  = 4'd0;
  localparam logic [ADDR_W-1:0] IX_MIN  = 4'd2;
  localparam logic [ADDR_W-1:0] IX_HOUR = 4'd4;
  localparam logic [ADDR_W-1:0] IX_DOW  = 4'd6;
  localparam logic [ADDR_W-1:0] IX_DOM  = 4'd7;
  localparam logic [ADDR_W-1:0] IX_MON  = 4'd8;
  localparam logic [ADDR_W-1:0] IX_YEAR = 4'd9;
  localparam logic [ADDR_W-1:0] IX_STAT = 4'd10;
  localparam logic [ADDR_W-1:0] IX_CTL  = 4'd11;

  // control bit positions
  localparam int CTL_HOLD = 7;
  localparam int CTL_BIN  = 2;
  localparam int CTL_H24  = 1;

  // stored byte -> plain value
  function automatic logic [6:0] to_plain(input logic [7:0] v, input logic bin);
    logic [6:0] tens;
    tens = 7'(v[7:4]) * 7'd10;
    return bin ? v[6:0] : (tens + 7'(v[3:0]));
  endfunction

  // plain value -> stored byte
  function automatic logic [7:0] to_stored(input logic [6:0] n, input logic bin);
    logic [6:0] hi;
    logic [6:0] lo;
    hi = n / 7'd10;
    lo = n % 7'd10;
    return bin ? {1'b0, n} : {hi[3:0], lo[3:0]};
  endfunction

  function automatic logic [6:0] month_len(input logic [6:0] m, input logic [6:0] y);
    case (m)
      7'd2:                        return (y[1:0] == 2'b00) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:     return 7'd30;
      default:                     return 7'd31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_roll.sv
module rtc_roll #(
  parameter int VAL_W = 7
) (
  input  logic [VAL_W-1:0] val,
  input  logic             inc,
  input  logic [VAL_W-1:0] lo,
  input  logic [VAL_W-1:0] hi,
  output logic [VAL_W-1:0] nxt,
  output logic             carry
);

  always_comb begin
    nxt   = val;
    carry = 1'b0;
    if (inc) begin
      if (val >= hi) begin
        nxt   = lo;
        carry = 1'b1;
      end else begin
        nxt = val + 1'b1;
      end
    end
  end

endmodule

// File: rtl/rtc_update_seq.sv
module rtc_update_seq #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int WARN_TICKS    = 8,
  parameter int UPDATE_TICKS  = 65
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic hold,
  output logic uip,
  output logic done,
  output logic advance
);

  localparam int CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST_CNT = CW'(TICKS_PER_SEC - 1);
  localparam logic [CW-1:0] RISE_CNT = CW'(TICKS_PER_SEC - 1 - WARN_TICKS);
  localparam logic [CW-1:0] FALL_CNT = CW'(UPDATE_TICKS - 1);

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap    = tick && (cnt == LAST_CNT);
  // a step needs an open window and no hold on this edge
  assign advance = wrap && uip && !hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      uip  <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        cnt <= wrap ? '0 : cnt + 1'b1;
        if (!uip && !hold && cnt == RISE_CNT) begin
          uip <= 1'b1;
        end else if (uip && cnt == FALL_CNT) begin
          uip  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_tk_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              advance,
  input  logic              bin_mode,
  input  logic              h24_mode,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output rtc_time_t         time_q
);

  localparam int NSM = 2;  // seconds and minutes share one range

  logic [6:0] hr_p, dow_p, dom_p, mon_p, yr_p;
  logic [6:0] sm_val [NSM];
  logic [6:0] sm_nxt [NSM];
  logic       sm_cy  [NSM];

  assign sm_val[0] = to_plain(time_q.sec, bin_mode);
  assign sm_val[1] = to_plain(time_q.min, bin_mode);
  assign hr_p      = to_plain({1'b0, time_q.hour[6:0]}, bin_mode);
  assign dow_p     = to_plain(time_q.dow, bin_mode);
  assign dom_p     = to_plain(time_q.dom, bin_mode);
  assign mon_p     = to_plain(time_q.mon, bin_mode);
  assign yr_p      = to_plain(time_q.year, bin_mode);

  for (genvar g = 0; g < NSM; g++) begin : g_sm
    logic inc_g;
    if (g == 0) begin : g_first
      assign inc_g = 1'b1;
    end else begin : g_chain
      assign inc_g = sm_cy[g-1];
    end
    rtc_roll #(.VAL_W(7)) u_roll (
      .val  (sm_val[g]),
      .inc  (inc_g),
      .lo   (7'd0),
      .hi   (7'd59),
      .nxt  (sm_nxt[g]),
      .carry(sm_cy[g])
    );
  end

  // 24-hour path
  logic [6:0] h24_nxt;
  logic       h24_cy;
  rtc_roll #(.VAL_W(7)) u_hr24 (
    .val(hr_p), .inc(sm_cy[NSM-1]), .lo(7'd0), .hi(7'd23),
    .nxt(h24_nxt), .carry(h24_cy)
  );

  // 12-hour path
  logic [6:0] h12_nxt;
  logic       h12_pm;
  logic       h12_cy;
  always_comb begin
    h12_nxt = hr_p;
    h12_pm  = time_q.hour[7];
    h12_cy  = 1'b0;
    if (sm_cy[NSM-1]) begin
      if (hr_p == 7'd11) begin
        h12_nxt = 7'd12;
        h12_pm  = ~time_q.hour[7];
        h12_cy  = time_q.hour[7];
      end else if (hr_p >= 7'd12) begin
        h12_nxt = 7'd1;
      end else begin
        h12_nxt = hr_p + 7'd1;
      end
    end
  end

  logic       day_cy;
  logic [6:0] dow_nxt, dom_nxt, mon_nxt, yr_nxt;
  logic       dow_cy, dom_cy, mon_cy, yr_cy;
  logic [6:0] dom_max;

  assign day_cy  = h24_mode ? h24_cy : h12_cy;
  assign dom_max = month_len(mon_p, yr_p);

  rtc_roll #(.VAL_W(7)) u_dow (
    .val(dow_p), .inc(day_cy), .lo(7'd1), .hi(7'd7),
    .nxt(dow_nxt), .carry(dow_cy)
  );
  rtc_roll #(.VAL_W(7)) u_dom (
    .val(dom_p), .inc(day_cy), .lo(7'd1), .hi(dom_max),
    .nxt(dom_nxt), .carry(dom_cy)
  );
  rtc_roll #(.VAL_W(7)) u_mon (
    .val(mon_p), .inc(dom_cy), .lo(7'd1), .hi(7'd12),
    .nxt(mon_nxt), .carry(mon_cy)
  );
  rtc_roll #(.VAL_W(7)) u_year (
    .val(yr_p), .inc(mon_cy), .lo(7'd0), .hi(7'd99),
    .nxt(yr_nxt), .carry(yr_cy)
  );

  rtc_time_t  nxt_t;
  logic [7:0] h12_byte;
  always_comb begin
    h12_byte   = to_stored(h12_nxt, bin_mode);
    nxt_t.sec  = to_stored(sm_nxt[0], bin_mode);
    nxt_t.min  = to_stored(sm_nxt[1], bin_mode);
    nxt_t.hour = h24_mode ? to_stored(h24_nxt, bin_mode) : {h12_pm, h12_byte[6:0]};
    nxt_t.dow  = to_stored(dow_nxt, bin_mode);
    nxt_t.dom  = to_stored(dom_nxt, bin_mode);
    nxt_t.mon  = to_stored(mon_nxt, bin_mode);
    nxt_t.year = to_stored(yr_nxt, bin_mode);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      time_q <= '{sec: 8'h00, min: 8'h00, hour: 8'h00, dow: 8'h01,
                  dom: 8'h01, mon: 8'h01, year: 8'h00};
    end else if (wr_en) begin
      case (wr_addr)
        IX_SEC:  time_q.sec  <= wr_data;
        IX_MIN:  time_q.min  <= wr_data;
        IX_HOUR: time_q.hour <= wr_data;
        IX_DOW:  time_q.dow  <= wr_data;
        IX_DOM:  time_q.dom  <= wr_data;
        IX_MON:  time_q.mon  <= wr_data;
        IX_YEAR: time_q.year <= wr_data;
        default: ;
      endcase
    end else if (advance) begin
      time_q <= nxt_t;
    end
  end

  logic unused_cy;
  assign unused_cy = yr_cy ^ dow_cy;

endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
  import rtc_tk_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int WARN_TICKS    = 8,
  parameter int UPDATE_TICKS  = 65
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              uip,
  output logic              upd_done
);

  logic      set_q, bin_q, h24_q;
  logic      advance;
  logic      is_time_ix;
  logic      time_we;
  rtc_time_t tm;
  logic [DATA_W-1:0] sec_now;

  assign sec_now = tm.sec;

  always_comb begin
    case (addr)
      IX_SEC, IX_MIN, IX_HOUR, IX_DOW, IX_DOM, IX_MON, IX_YEAR: is_time_ix = 1'b1;
      default: is_time_ix = 1'b0;
    endcase
  end

  // time fields are locked during the window unless hold is set
  assign time_we = wr_en && is_time_ix && (!uip || set_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      set_q <= 1'b0;
      bin_q <= 1'b0;
      h24_q <= 1'b1;
    end else if (wr_en && addr == IX_CTL) begin
      set_q <= wdata[CTL_HOLD];
      bin_q <= wdata[CTL_BIN];
      h24_q <= wdata[CTL_H24];
    end
  end

  rtc_update_seq #(
    .TICKS_PER_SEC(TICKS_PER_SEC),
    .WARN_TICKS   (WARN_TICKS),
    .UPDATE_TICKS (UPDATE_TICKS)
  ) u_seq (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .hold   (set_q),
    .uip    (uip),
    .done   (upd_done),
    .advance(advance)
  );

  rtc_calendar u_cal (
    .clk     (clk),
    .rst     (rst),
    .advance (advance),
    .bin_mode(bin_q),
    .h24_mode(h24_q),
    .wr_en   (time_we),
    .wr_addr (addr),
    .wr_data (wdata),
    .time_q  (tm)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      case (addr)
        IX_SEC:  rdata <= tm.sec;
        IX_MIN:  rdata <= tm.min;
        IX_HOUR: rdata <= tm.hour;
        IX_DOW:  rdata <= tm.dow;
        IX_DOM:  rdata <= tm.dom;
        IX_MON:  rdata <= tm.mon;
        IX_YEAR: rdata <= tm.year;
        IX_STAT: rdata <= {uip, 7'b0};
        IX_CTL:  rdata <= {set_q, 4'b0, bin_q, h24_q, 1'b0};
        default: rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/rtc_timekeeper_chk.sv
module rtc_timekeeper_chk (
  input logic       clk,
  input logic       rst,
  input logic       tick,
  input logic       wr_en,
  input logic       uip,
  input logic       upd_done,
  input logic       set_q,
  input logic [7:0] sec_now
);

  // R9: done lasts one cycle
  p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
    upd_done |=> !upd_done);

  // R9: done coincides with the flag falling
  p_done_on_fall_r9: assert property (@(posedge clk) disable iff (rst)
    upd_done |-> (!uip && $past(uip)));

  p_fall_gives_done_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(uip)) |-> upd_done);

  // R7: the window never opens under hold
  p_no_rise_in_hold_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(uip) |-> !$past(set_q));

  // R7: hold freezes the seconds field apart from host writes
  p_hold_freezes_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(set_q) && !$past(wr_en) && !$past(rst)) |-> $stable(sec_now));

  // R11: no step without a tick
  p_tick_needed_r11: assert property (@(posedge clk) disable iff (rst)
    (!$past(tick) && !$past(wr_en) && !$past(rst)) |-> $stable(sec_now));

  // R8: a step only happens inside the window
  p_step_in_window_r8: assert property (@(posedge clk) disable iff (rst)
    (!$stable(sec_now) && !$past(wr_en) && !$past(rst)) |-> $past(uip));

endmodule

bind rtc_timekeeper rtc_timekeeper_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .tick    (tick),
  .wr_en   (wr_en),
  .uip     (uip),
  .upd_done(upd_done),
  .set_q   (set_q),
  .sec_now (sec_now)
);

// File: tb/rtc_timekeeper_bench.sv
module rtc_timekeeper_bench;

  localparam int TPS  = 100;
  localparam int WARN = 8;
  localparam int UPD  = 65;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b1;
  logic       wr_en = 1'b0;
  logic [3:0] addr = 4'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       uip;
  logic       upd_done;

  int total = 0;
  int bad = 0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } exp_item_t;

  exp_item_t sb_q[$];
  logic rd_vld = 1'b0;
  logic rd_vld_d = 1'b0;

  always #10 clk = ~clk;

  rtc_timekeeper #(
    .TICKS_PER_SEC(TPS), .WARN_TICKS(WARN), .UPDATE_TICKS(UPD)
  ) u_rtc_timekeeper (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .uip(uip), .upd_done(upd_done)
  );

  // monitor: compare registered read data against the scoreboard
  always @(posedge clk) rd_vld_d <= rd_vld;
  always @(negedge clk) begin
    if (rd_vld_d) begin
      exp_item_t it;
      it = sb_q.pop_front();
      total++;
      if (rdata !== it.exp) begin
        bad++;
        $display("FAIL %s: actual=%02h expected=%02h", it.tag, rdata, it.exp);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
    exp_item_t it;
    @(negedge clk);
    addr = a;
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    rd_vld = 1'b1;
    @(negedge clk);
    rd_vld = 1'b0;
  endtask

  task automatic wait_uip(input logic lvl);
    int g = 0;
    while (uip !== lvl && g < 1000) begin
      @(negedge clk);
      g++;
    end
  endtask

  task automatic wait_done();
    int g = 0;
    do begin
      @(negedge clk);
      g++;
    end while (!upd_done && g < 1000);
    chk("done pulse seen", int'(upd_done), 1);
  endtask

  // load under hold, release, wait for one full step
  task automatic load_and_step(input logic [7:0] ctl, input logic [7:0] s,
                               input logic [7:0] m, input logic [7:0] h,
                               input logic [7:0] dw, input logic [7:0] dm,
                               input logic [7:0] mo, input logic [7:0] yr);
    wr(4'd11, ctl | 8'h80);
    wait_uip(1'b0);
    wr(4'd0, s); wr(4'd2, m); wr(4'd4, h); wr(4'd6, dw);
    wr(4'd7, dm); wr(4'd8, mo); wr(4'd9, yr);
    wr(4'd11, ctl);
    wait_done();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int first_chg;
    int fall_at;
    int done_at_fall;
    int stray;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset values, R12 map
    rd(4'd0,  8'h00, "R1 sec");
    rd(4'd4,  8'h00, "R1 hour");
    rd(4'd6,  8'h01, "R1 dow");
    rd(4'd8,  8'h01, "R1 month");
    rd(4'd11, 8'h02, "R1 ctl");
    rd(4'd10, 8'h00, "R1 status");
    rd(4'd3,  8'h00, "R12 unused index");

    // R7: hold freezes everything, writes land
    wr(4'd11, 8'h82);
    wait_uip(1'b0);
    wr(4'd0, 8'h10);
    rd(4'd11, 8'h82, "R12 ctl keeps 7,2,1");
    stray = 0;
    for (int i = 0; i < 250; i++) begin
      @(negedge clk);
      if (uip || upd_done) stray++;
    end
    chk("R7 no window under hold", stray, 0);
    rd(4'd0, 8'h10, "R7 sec frozen");
    rd(4'd10, 8'h00, "R7 status low");

    // R8 R9 R10 window timing and blocked write
    wr(4'd0, 8'h20);
    wr(4'd11, 8'h02);
    wait_uip(1'b1);
    wr_en = 1'b1; addr = 4'd0; wdata = 8'h45;
    first_chg = -1; fall_at = -1; done_at_fall = 0;
    for (int n = 1; n < 300 && fall_at < 0; n++) begin
      @(negedge clk);
      if (n == 1) wr_en = 1'b0;
      if (first_chg < 0 && rdata == 8'h21) first_chg = n;
      if (!uip) begin
        fall_at = n;
        done_at_fall = int'(upd_done);
      end
    end
    tick = 1'b0;  // R11: freeze right at the close of the window
    chk("R8 step lands WARN ticks after rise", first_chg, WARN + 1);
    chk("R9 window length", fall_at, WARN + UPD);
    chk("R9 done with fall", done_at_fall, 1);
    chk("R10 write during window dropped", int'(rdata), 8'h21);

    stray = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (uip || upd_done) stray++;
    end
    chk("R11 no window without tick", stray, 0);
    rd(4'd0, 8'h21, "R11 sec held");
    tick = 1'b1;

    // R2 BCD digit carry
    load_and_step(8'h02, 8'h09, 8'h30, 8'h05, 8'h02, 8'h10, 8'h06, 8'h20);
    rd(4'd0, 8'h10, "R2 bcd digit carry");
    rd(4'd2, 8'h30, "R2 min untouched");

    // R2 R5 full BCD rollover
    load_and_step(8'h02, 8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
    rd(4'd0, 8'h00, "R2 sec wrap");
    rd(4'd2, 8'h00, "R2 min wrap");
    rd(4'd4, 8'h00, "R2 hour wrap");
    rd(4'd6, 8'h01, "R5 dow wrap");
    rd(4'd7, 8'h01, "R5 dom wrap");
    rd(4'd8, 8'h01, "R5 month wrap");
    rd(4'd9, 8'h00, "R5 year wrap");

    // R5 30-day month
    load_and_step(8'h02, 8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h04, 8'h25);
    rd(4'd7, 8'h01, "R5 april 30 wraps");
    rd(4'd8, 8'h05, "R5 month to may");

    // R3 R6 binary, common-year February
    load_and_step(8'h06, 8'd59, 8'd59, 8'd23, 8'd3, 8'd28, 8'd2, 8'd23);
    rd(4'd0, 8'h00, "R3 bin sec");
    rd(4'd6, 8'h04, "R3 bin dow");
    rd(4'd7, 8'h01, "R6 feb 28 wraps");
    rd(4'd8, 8'h03, "R6 march");
    rd(4'd9, 8'd23, "R3 bin year");

    // R3 R6 binary, leap-year February
    load_and_step(8'h06, 8'd59, 8'd59, 8'd23, 8'd3, 8'd28, 8'd2, 8'd24);
    rd(4'd7, 8'd29, "R6 feb 29 leap");
    rd(4'd8, 8'd2, "R6 still feb");
    rd(4'd4, 8'd0, "R3 bin hour wrap");

    // R4 12-hour forms
    load_and_step(8'h00, 8'h59, 8'h59, 8'h11, 8'h03, 8'h15, 8'h05, 8'h20);
    rd(4'd4, 8'h92, "R4 11am to 12pm");
    rd(4'd7, 8'h15, "R4 noon no date carry");
    load_and_step(8'h00, 8'h59, 8'h59, 8'h91, 8'h03, 8'h15, 8'h05, 8'h20);
    rd(4'd4, 8'h12, "R4 11pm to 12am");
    rd(4'd7, 8'h16, "R4 midnight carries date");
    rd(4'd6, 8'h04, "R4 midnight carries dow");
    load_and_step(8'h00, 8'h59, 8'h59, 8'h92, 8'h03, 8'h15, 8'h05, 8'h20);
    rd(4'd4, 8'h81, "R4 12pm to 1pm");

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule